// File: doc/BRIEF.md
# Bit Scan Unit

This block locates a set bit inside an operand. In forward mode it reports the position of the lowest set bit. In reverse mode it reports the position of the highest set bit. The operand may be 16, 32 or 64 bits wide. The caller supplies four things: the source value, a size code, a direction select and the current destination value. After one clock the block returns three things:

- the new destination value;
- a zero flag;
- a mask that marks the other five arithmetic flags as undefined.

When the source holds at least one set bit, the destination becomes the bit position, zero-extended to the full destination width. When the searched bits are all zero, the destination is passed back unchanged and the zero flag is raised.

The unit sits in an execute stage. An input strobe launches one operation. One cycle later the result appears together with a single-cycle output-valid pulse. The result registers hold their contents until the next strobe. Two parameters shape the block: the widest operand width, from which the two narrower sizes are derived, and the priority-encoder variant (a log-depth tree or a flat loop).

Top module: `bscan_unit`

## Requirements
- R1: With `dir_i` = 0 (forward) and a non-zero searched value, `dest_o` holds the position of the least-significant set bit.
- R2: With `dir_i` = 1 (reverse) and a non-zero searched value, `dest_o` holds the position of the most-significant set bit.
- R3: The position is an unsigned offset from bit 0 in both directions, and it is zero-extended: every `dest_o` bit above the index field is 0.
- R4: `zf_o` is 0 when the searched value has a set bit and 1 when it does not.
- R5: When the searched value is zero, `dest_o` equals the `dest_i` value presented with the strobe.
- R6: The size code `size_i` selects the searched width:
  - 0 selects 16 bits;
  - 1 selects 32 bits;
  - 2 selects 64 bits;
  - the spare code 3 behaves like 64 bits.
- R7: For the 16- and 32-bit sizes, source bits at or above the selected width are ignored.
- R8: After every operation, `undef_o` is all ones. Bit 0 marks the carry flag, bit 1 parity, bit 2 auxiliary carry, bit 3 sign and bit 4 overflow.
- R9: Results and `out_valid_o` appear on the clock edge after the one that samples `in_valid_i` high. `out_valid_o` is a single-cycle pulse. Without a strobe, `dest_o` and `zf_o` hold their values.
- R10: After synchronous reset, `out_valid_o`, `dest_o`, `zf_o` and `undef_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Launches one scan |
| src_i | input | MAX_W | Value to search |
| size_i | input | 2 | Operand size code |
| dir_i | input | 1 | 0 = forward (lowest bit), 1 = reverse (highest bit) |
| dest_i | input | MAX_W | Current destination value |
| out_valid_o | output | 1 | Result pulse, one cycle after the strobe |
| dest_o | output | MAX_W | New destination value |
| zf_o | output | 1 | Zero flag |
| undef_o | output | 5 | Undefined-flag mask |

## Verification
The bench sweeps every single-bit source at every size and in both directions. Each sweep includes bits placed above a narrow width. A design that did not mask the upper bits would report a position there instead of raising the zero flag and keeping the destination. All-ones and all-zero sources separate the two directions at their extreme positions (0 versus width-1). They also show whether the old destination survives a zero search, or whether a design wrongly writes 0 there. Random values with a dirty destination compare the result against a bit-by-bit reference loop. Any stray bit left above the index field, or a forward/reverse swap, shows up as a mismatch. A quiet cycle after each operation checks that the pulse ends and that the result holds.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      SZ_16  = 2'd0,
      SZ_32  = 2'd1,
      SZ_64  = 2'd2,
      SZ_SPR = 2'd3
   } size_e;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } dir_e;

   localparam int FLAG_N   = 5;
   localparam int FL_CARRY = 0;
   localparam int FL_PAR   = 1;
   localparam int FL_AUX   = 2;
   localparam int FL_SIGN  = 3;
   localparam int FL_OVF   = 4;

   localparam logic [FLAG_N-1:0] UNDEF_ALL =
      FLAG_N'((1 << FL_CARRY) | (1 << FL_PAR) | (1 << FL_AUX) |
              (1 << FL_SIGN)  | (1 << FL_OVF));

endpackage

// File: rtl/bscan_width_gate.sv
module bscan_width_gate
   import bscan_pkg::*;
#(
   parameter int MAX_W = 64
) (
   input  logic [MAX_W-1:0] src_i,
   input  logic [1:0]       size_i,
   output logic [MAX_W-1:0] gated_o
);
   localparam int W_NARROW = MAX_W / 4;
   localparam int W_MID    = MAX_W / 2;

   localparam logic [MAX_W-1:0] M_NARROW = {{(MAX_W-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};
   localparam logic [MAX_W-1:0] M_MID    = {{(MAX_W-W_MID){1'b0}}, {W_MID{1'b1}}};
   localparam logic [MAX_W-1:0] M_FULL   = {MAX_W{1'b1}};

   logic [MAX_W-1:0] sel_mask;

   always_comb begin
      unique case (size_e'(size_i))
         SZ_16:   sel_mask = M_NARROW;
         SZ_32:   sel_mask = M_MID;
         default: sel_mask = M_FULL;
      endcase
   end

   assign gated_o = src_i & sel_mask;

endmodule

// File: rtl/bscan_bit_mirror.sv
module bscan_bit_mirror #(
   parameter int MAX_W = 64
) (
   input  logic [MAX_W-1:0] vec_i,
   output logic [MAX_W-1:0] vec_o
);
   for (genvar b = 0; b < MAX_W; b++) begin : g_bit
      assign vec_o[b] = vec_i[MAX_W-1-b];
   end
endmodule

// File: rtl/bscan_lsb_enc.sv
module bscan_lsb_enc #(
   parameter int MAX_W    = 64,
   parameter bit ENC_TREE = 1'b1
) (
   input  logic [MAX_W-1:0]         vec_i,
   output logic                     found_o,
   output logic [$clog2(MAX_W)-1:0] idx_o
);
   localparam int IDX_W = $clog2(MAX_W);

   if (ENC_TREE) begin : g_tree
      for (genvar l = 1; l <= IDX_W; l++) begin : g_lvl
         localparam int NODES = MAX_W >> l;
         logic [NODES-1:0]        v;
         logic [NODES-1:0][l-1:0] ix;
         for (genvar n = 0; n < NODES; n++) begin : g_node
            if (l == 1) begin : g_leaf
               assign v[n]  = vec_i[2*n] | vec_i[2*n+1];
               assign ix[n] = ~vec_i[2*n];
            end else begin : g_inner
               assign v[n]  = g_lvl[l-1].v[2*n] | g_lvl[l-1].v[2*n+1];
               assign ix[n] = g_lvl[l-1].v[2*n] ? {1'b0, g_lvl[l-1].ix[2*n]}
                                                : {1'b1, g_lvl[l-1].ix[2*n+1]};
            end
         end
      end
      assign found_o = g_lvl[IDX_W].v[0];
      assign idx_o   = g_lvl[IDX_W].ix[0];
   end else begin : g_loop
      always_comb begin
         idx_o = '0;
         for (int i = MAX_W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = i[IDX_W-1:0];
         end
      end
      assign found_o = |vec_i;
   end

endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
   import bscan_pkg::*;
#(
   parameter int MAX_W    = 64,
   parameter bit ENC_TREE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid_i,
   input  logic [MAX_W-1:0]     src_i,
   input  logic [1:0]           size_i,
   input  logic                 dir_i,
   input  logic [MAX_W-1:0]     dest_i,
   output logic                 out_valid_o,
   output logic [MAX_W-1:0]     dest_o,
   output logic                 zf_o,
   output logic [FLAG_N-1:0]    undef_o
);
   localparam int IDX_W = $clog2(MAX_W);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_W - 1);

   if (MAX_W < 8 || (MAX_W & (MAX_W - 1)) != 0) begin : g_bad_width
      $error("bscan_unit: MAX_W must be a power of two of at least 8");
   end

   logic [MAX_W-1:0] gated;
   logic [MAX_W-1:0] mirrored;
   logic [MAX_W-1:0] search_vec;
   logic             found;
   logic [IDX_W-1:0] raw_idx;
   logic [IDX_W-1:0] pos;
   logic [MAX_W-1:0] next_dest;

   bscan_width_gate #(.MAX_W(MAX_W)) gate_i (
      .src_i   (src_i),
      .size_i  (size_i),
      .gated_o (gated)
   );

   bscan_bit_mirror #(.MAX_W(MAX_W)) mirror_i (
      .vec_i (gated),
      .vec_o (mirrored)
   );

   assign search_vec = (dir_e'(dir_i) == DIR_REV) ? mirrored : gated;

   bscan_lsb_enc #(.MAX_W(MAX_W), .ENC_TREE(ENC_TREE)) enc_i (
      .vec_i   (search_vec),
      .found_o (found),
      .idx_o   (raw_idx)
   );

   assign pos       = (dir_e'(dir_i) == DIR_REV) ? (TOP_IDX - raw_idx) : raw_idx;
   assign next_dest = found ? {{(MAX_W-IDX_W){1'b0}}, pos} : dest_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid_o <= 1'b0;
         dest_o      <= '0;
         zf_o        <= 1'b0;
         undef_o     <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            dest_o  <= next_dest;
            zf_o    <= ~found;
            undef_o <= UNDEF_ALL;
         end
      end
   end

endmodule

// File: rtl/bscan_unit_chk.sv
module bscan_unit_chk
   import bscan_pkg::*;
#(
   parameter int MAX_W = 64
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid_i,
   input logic [MAX_W-1:0]  src_i,
   input logic [1:0]        size_i,
   input logic              dir_i,
   input logic [MAX_W-1:0]  dest_i,
   input logic              out_valid_o,
   input logic [MAX_W-1:0]  dest_o,
   input logic              zf_o,
   input logic [FLAG_N-1:0] undef_o
);
   localparam int IDX_W = $clog2(MAX_W);

   logic [MAX_W-1:0] gate_c, gate_q, dest_q, low_m;
   logic             dir_q;
   logic [1:0]       size_q;
   logic [IDX_W-1:0] idx;

   always_comb begin
      case (size_i)
         2'd0:    gate_c = src_i & {{(MAX_W-MAX_W/4){1'b0}}, {(MAX_W/4){1'b1}}};
         2'd1:    gate_c = src_i & {{(MAX_W-MAX_W/2){1'b0}}, {(MAX_W/2){1'b1}}};
         default: gate_c = src_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gate_q <= '0; dest_q <= '0; dir_q <= 1'b0; size_q <= '0;
      end else if (in_valid_i) begin
         gate_q <= gate_c; dest_q <= dest_i; dir_q <= dir_i; size_q <= size_i;
      end
   end

   assign idx   = dest_o[IDX_W-1:0];
   assign low_m = (MAX_W'(1) << idx) - MAX_W'(1);

   assert_lowest_R1: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !zf_o && !dir_q) |-> (gate_q[idx] && ((gate_q & low_m) == '0)));

   assert_highest_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !zf_o && dir_q) |-> ((gate_q >> idx) == MAX_W'(1)));

   assert_zero_ext_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !zf_o) |-> ((dest_o >> IDX_W) == '0));

   assert_zflag_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid_o |-> (zf_o == (gate_q == '0)));

   assert_keep_dest_R5: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && zf_o) |-> (dest_o == dest_q));

   assert_narrow_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid_o && !zf_o && size_q == 2'd0) |-> (int'(idx) < MAX_W/4));

   assert_undef_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid_o |-> (undef_o == UNDEF_ALL));

   assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      in_valid_i |=> out_valid_o);

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid_i |=> (!out_valid_o && $stable(dest_o) && $stable(zf_o)));

endmodule

bind bscan_unit bscan_unit_chk #(.MAX_W(MAX_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .in_valid_i  (in_valid_i),
   .src_i       (src_i),
   .size_i      (size_i),
   .dir_i       (dir_i),
   .dest_i      (dest_i),
   .out_valid_o (out_valid_o),
   .dest_o      (dest_o),
   .zf_o        (zf_o),
   .undef_o     (undef_o)
);

// File: tb/bscan_unit_tb_top.sv
module bscan_unit_tb_top;
   localparam int W = 64;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid_i = 1'b0;
   logic [W-1:0]  src_i = '0;
   logic [1:0]    size_i = '0;
   logic          dir_i = 1'b0;
   logic [W-1:0]  dest_i = '0;
   logic          out_valid_o;
   logic [W-1:0]  dest_o;
   logic          zf_o;
   logic [4:0]    undef_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bscan_unit #(.MAX_W(W)) dut_i (
      .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .src_i(src_i),
      .size_i(size_i), .dir_i(dir_i), .dest_i(dest_i),
      .out_valid_o(out_valid_o), .dest_o(dest_o), .zf_o(zf_o), .undef_o(undef_o)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One scan: drive, let one edge capture, compare against a reference loop.
   task automatic run_op(input logic [1:0] sz, input logic dr,
                         input logic [W-1:0] s, input logic [W-1:0] d);
      int wid;
      bit fnd;
      int pos;
      logic [W-1:0] exp_d;
      string tag;
      wid = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
      fnd = 1'b0;
      pos = 0;
      for (int i = 0; i < wid; i++) begin
         if (s[i]) begin
            if (dr || !fnd) pos = i;
            fnd = 1'b1;
         end
      end
      exp_d = fnd ? W'(pos) : d;
      tag = !fnd ? "R5" : (dr ? "R2" : "R1");
      @(negedge clk);
      in_valid_i = 1'b1; src_i = s; size_i = sz; dir_i = dr; dest_i = d;
      @(negedge clk);
      in_valid_i = 1'b0;
      chk(out_valid_o == 1'b1, "R9 pulse", W'(out_valid_o), W'(1));
      chk(dest_o == exp_d, tag, dest_o, exp_d);
      chk(zf_o == !fnd, "R4", W'(zf_o), W'(!fnd));
      chk(undef_o == 5'h1f, "R8", W'(undef_o), W'(5'h1f));
      if (fnd) chk((dest_o >> 6) == '0, "R3", dest_o, exp_d);
      if (sz < 2'd2 && (s >> wid) != '0)
         chk(dest_o == exp_d, "R7", dest_o, exp_d);
      if (sz == 2'd3)
         chk(dest_o == exp_d, "R6", dest_o, exp_d);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] held_d;
      logic         held_z;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      chk(out_valid_o == 1'b0, "R10", W'(out_valid_o), '0);
      chk(dest_o == '0, "R10", dest_o, '0);
      chk(zf_o == 1'b0, "R10", W'(zf_o), '0);
      chk(undef_o == '0, "R10", W'(undef_o), '0);

      for (int sz = 0; sz < 4; sz++) begin
         for (int dr = 0; dr < 2; dr++) begin
            for (int b = 0; b < W; b++)
               run_op(2'(sz), dr[0], W'(1) << b, 64'hA5A5_0000_DEAD_BEEF);
            run_op(2'(sz), dr[0], '1, 64'h1234_5678_9ABC_DEF0);
            run_op(2'(sz), dr[0], '0, 64'hFEDC_BA98_7654_3210);
            run_op(2'(sz), dr[0], 64'hFFFF_FFFF_0000_0000, 64'h0BAD_F00D_0BAD_F00D);
            for (int r = 0; r < 100; r++) begin
               logic [W-1:0] rv;
               rv = {$urandom, $urandom};
               if (r % 4 == 0) rv = rv & (rv << 7) & (rv >> 3);
               run_op(2'(sz), dr[0], rv, {$urandom, $urandom});
            end
         end
      end

      // R9: without a strobe the pulse ends and the result holds.
      run_op(2'd2, 1'b0, 64'h0000_0100_0000_0000, '1);
      held_d = dest_o;
      held_z = zf_o;
      src_i = 64'h1; dir_i = 1'b1; dest_i = 64'h55;
      @(negedge clk);
      chk(out_valid_o == 1'b0, "R9 no-pulse", W'(out_valid_o), '0);
      chk(dest_o == held_d, "R9 hold", dest_o, held_d);
      chk(zf_o == held_z, "R9 hold", W'(zf_o), W'(held_z));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule